// File: doc/BRIEF.md
# Snooping Transaction Buffer Controller

This block sits between an inbound bus port and local memory. Each accepted transaction (address, data, direction, lock qualifier) is parked in one of a pool of paired address/data entries. While an entry is held, its address stays visible. Every new request is compared with it at cache-line granularity, so that buffered writes can retire to memory out of order without breaking read-after-write or write-after-write ordering on the same line.

When snooping is on, the controller sends one cache snoop per accepted transaction to the processor's L1 data cache, in exactly the order the transactions were accepted. An entry may drain to memory only after its snoop has resolved. A modified-hit response parks the entry until the cache reports that its push is done.

The processor side presents the address of its current local-memory access, and the block grants that access unless a buffered locked transaction covers the same line. A configuration input turns snooping off. Transactions accepted while it is set skip the snoop stage, and their lock qualifier is dropped.

Top module: `snoop_txn_buf`

## Requirements
- R1: After reset, in_ready_o is high, snp_valid_o and mem_valid_o are low, and cpu_grant_o is low while cpu_valid_i is low.
- R2: The pool holds N_ENT (default 8) transactions. While all entries are occupied, in_ready_o is low, and it rises again once an entry drains.
- R3: Each accepted transaction is presented on the memory port exactly once, with its own address, data and write flag. With snooping on, this happens only after its snoop has resolved.
- R4: Snoop requests are issued one at a time in acceptance order. snp_valid_o and snp_addr_o are held until a response arrives.
- R5: A transaction accepted while no_snoop_i is high produces no snoop request.
- R6: A new request whose address matches a buffered entry's line, with bits [4:0] ignored, is stalled (in_ready_o low) when either it or that entry is a write. It is stalled until that entry drains.
- R7: With snooping on, a buffered locked transaction holds cpu_grant_o low for any processor address in the same line until that transaction drains. Other lines are granted.
- R8: A locked transaction accepted while no_snoop_i is high does not hold off the processor.
- R9: Snoop response codes on snp_resp_i are 0 clean, 1 modified hit and 2 push done. After a modified hit, the entry is not presented to memory until a push-done response arrives.
- R10: New transactions take the lowest-numbered free entry, and memory drains the lowest-numbered ready entry first. A newer transaction in a lower entry therefore retires before an older one in a higher entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| no_snoop_i | input | 1 | Snooping disabled for transactions accepted now |
| in_valid_i | input | 1 | Inbound request valid |
| in_ready_o | output | 1 | Inbound request accepted this cycle |
| in_addr_i | input | AW | Inbound address |
| in_data_i | input | DW | Inbound write data |
| in_write_i | input | 1 | Inbound request is a write |
| in_lock_i | input | 1 | Inbound request is locked |
| cpu_valid_i | input | 1 | Processor local-memory access pending |
| cpu_addr_i | input | AW | Processor access address |
| cpu_grant_o | output | 1 | Processor access may proceed |
| snp_valid_o | output | 1 | Snoop request |
| snp_addr_o | output | AW | Snoop address |
| snp_resp_valid_i | input | 1 | Snoop response valid |
| snp_resp_i | input | 2 | Snoop response code |
| mem_valid_o | output | 1 | Memory access request |
| mem_ready_i | input | 1 | Memory accepts request |
| mem_addr_o | output | AW | Memory address |
| mem_data_o | output | DW | Memory write data |
| mem_write_o | output | 1 | Memory access is a write |

## Verification
The bench builds the block with its default parameters: eight entries, 32-bit address and data, and 32-byte lines. With eight entries, the full-pool stall can be reached with eight back-to-back writes while memory is held off. Holding memory off also fills the low entries and then frees them again, which makes a newer write retire ahead of an older one. The 32-byte line lets the bench probe offsets 0x1C and 0x20 against the same line base, which tests the comparison boundary for both hazard stalls and lock hold-off.

// File: rtl/stb_pkg.sv
package stb_pkg;
  typedef enum logic [1:0] {
    SR_CLEAN = 2'd0,
    SR_HITM  = 2'd1,
    SR_DONE  = 2'd2
  } snp_resp_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_REQ,
    S_PUSH
  } snp_st_e;
endpackage

// File: rtl/stb_pick_lowest.sv
module stb_pick_lowest #(
  parameter int N  = 8,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  always_comb begin
    idx_o = '0;
    any_o = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        idx_o = IW'(i);
        any_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/stb_order_fifo.sv
module stb_order_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 3,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] data_o,
  output logic         empty_o,
  output logic         full_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [PW:0]   cnt_q;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == (PW+1)'(DEPTH));
  assign data_o  = mem_q[rp_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (push_i) begin
        mem_q[wp_q] <= data_i;
        wp_q        <= (wp_q == PW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
      end
      if (pop_i) rp_q <= (rp_q == PW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
      cnt_q <= cnt_q + (PW+1)'(push_i) - (PW+1)'(pop_i);
    end
  end

  // R4: order queue never overruns
  p_fifo_no_overflow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> !push_i || pop_i);
endmodule

// File: rtl/snoop_txn_buf.sv
module snoop_txn_buf
  import stb_pkg::*;
#(
  parameter int N_ENT  = 8,
  parameter int AW     = 32,
  parameter int DW     = 32,
  parameter int LINE_W = 5,
  localparam int IW    = $clog2(N_ENT)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          no_snoop_i,
  input  logic          in_valid_i,
  output logic          in_ready_o,
  input  logic [AW-1:0] in_addr_i,
  input  logic [DW-1:0] in_data_i,
  input  logic          in_write_i,
  input  logic          in_lock_i,
  input  logic          cpu_valid_i,
  input  logic [AW-1:0] cpu_addr_i,
  output logic          cpu_grant_o,
  output logic          snp_valid_o,
  output logic [AW-1:0] snp_addr_o,
  input  logic          snp_resp_valid_i,
  input  logic [1:0]    snp_resp_i,
  output logic          mem_valid_o,
  input  logic          mem_ready_i,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_data_o,
  output logic          mem_write_o
);
  logic [N_ENT-1:0] vld_q, wr_q, lk_q, ok_q;
  logic [AW-1:0]    addr_q [N_ENT];
  logic [DW-1:0]    data_q [N_ENT];

  logic [N_ENT-1:0] conflict, lk_hit;
  logic [IW-1:0]    alloc_idx, mem_idx, cur_q, fifo_head;
  logic             free_any, acc, mem_fire;
  logic             fifo_empty, fifo_full, fifo_pop;
  snp_st_e          st_q;

  for (genvar i = 0; i < N_ENT; i++) begin : g_cmp
    logic in_line, cpu_line;
    assign in_line     = addr_q[i][AW-1:LINE_W] == in_addr_i[AW-1:LINE_W];
    assign cpu_line    = addr_q[i][AW-1:LINE_W] == cpu_addr_i[AW-1:LINE_W];
    assign conflict[i] = vld_q[i] && in_line && (wr_q[i] || in_write_i);
    assign lk_hit[i]   = vld_q[i] && lk_q[i] && cpu_line;
  end

  stb_pick_lowest #(.N(N_ENT)) i_free_pick (
    .req_i (~vld_q),
    .idx_o (alloc_idx),
    .any_o (free_any)
  );

  stb_pick_lowest #(.N(N_ENT)) i_drain_pick (
    .req_i (vld_q & ok_q),
    .idx_o (mem_idx),
    .any_o (mem_valid_o)
  );

  assign in_ready_o  = free_any && !(|conflict);
  assign acc         = in_valid_i && in_ready_o;
  assign cpu_grant_o = cpu_valid_i && !(|lk_hit);
  assign mem_addr_o  = addr_q[mem_idx];
  assign mem_data_o  = data_q[mem_idx];
  assign mem_write_o = wr_q[mem_idx];
  assign mem_fire    = mem_valid_o && mem_ready_i;

  assign fifo_pop    = (st_q == S_IDLE) && !fifo_empty;
  assign snp_valid_o = (st_q == S_REQ);
  assign snp_addr_o  = addr_q[cur_q];

  stb_order_fifo #(.DEPTH(N_ENT), .W(IW)) i_order (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (acc && !no_snoop_i),
    .data_i  (alloc_idx),
    .pop_i   (fifo_pop),
    .data_o  (fifo_head),
    .empty_o (fifo_empty),
    .full_o  (fifo_full)
  );

  logic snp_clear;
  assign snp_clear = snp_resp_valid_i &&
                     (((st_q == S_REQ)  && snp_resp_i == SR_CLEAN) ||
                      ((st_q == S_PUSH) && snp_resp_i == SR_DONE));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= S_IDLE;
      cur_q <= '0;
    end else begin
      unique case (st_q)
        S_IDLE: if (fifo_pop) begin
          cur_q <= fifo_head;
          st_q  <= S_REQ;
        end
        S_REQ: if (snp_resp_valid_i) begin
          if (snp_resp_i == SR_CLEAN)     st_q <= S_IDLE;
          else if (snp_resp_i == SR_HITM) st_q <= S_PUSH;
        end
        S_PUSH: if (snp_clear) st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      wr_q  <= '0;
      lk_q  <= '0;
      ok_q  <= '0;
      for (int i = 0; i < N_ENT; i++) begin
        addr_q[i] <= '0;
        data_q[i] <= '0;
      end
    end else begin
      if (mem_fire) vld_q[mem_idx] <= 1'b0;
      if (snp_clear) ok_q[cur_q] <= 1'b1;
      if (acc) begin
        vld_q[alloc_idx]  <= 1'b1;
        wr_q[alloc_idx]   <= in_write_i;
        lk_q[alloc_idx]   <= in_lock_i && !no_snoop_i;
        ok_q[alloc_idx]   <= no_snoop_i;
        addr_q[alloc_idx] <= in_addr_i;
        data_q[alloc_idx] <= in_data_i;
      end
    end
  end

  // R2: a refused request never grows the pool
  p_no_alloc_stall_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && !in_ready_o |=> $countones(vld_q) <= $past($countones(vld_q)));

  // R4: snoop request held steady until answered
  p_snoop_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_valid_o && !snp_resp_valid_i |=> snp_valid_o && $stable(snp_addr_o));

  // R9: entry under push is never sent to memory
  p_push_blocks_mem_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_PUSH) |-> !(mem_valid_o && mem_idx == cur_q));
endmodule

// File: tb/test_snoop_txn_buf.sv
module test_snoop_txn_buf;
  localparam int AW = 32;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic no_snoop_i = 1'b0;
  logic in_valid_i = 1'b0, in_write_i = 1'b0, in_lock_i = 1'b0;
  logic [AW-1:0] in_addr_i = '0;
  logic [DW-1:0] in_data_i = '0;
  logic cpu_valid_i = 1'b0;
  logic [AW-1:0] cpu_addr_i = '0;
  logic snp_resp_valid_i = 1'b0;
  logic [1:0] snp_resp_i = 2'd0;
  logic mem_ready_i = 1'b0;
  logic in_ready_o, cpu_grant_o, snp_valid_o, mem_valid_o, mem_write_o;
  logic [AW-1:0] snp_addr_o, mem_addr_o;
  logic [DW-1:0] mem_data_o;

  always #5 clk = ~clk;

  snoop_txn_buf i_snoop_txn_buf (
    .clk_i(clk), .rst_ni(rst_ni), .no_snoop_i(no_snoop_i),
    .in_valid_i(in_valid_i), .in_ready_o(in_ready_o), .in_addr_i(in_addr_i),
    .in_data_i(in_data_i), .in_write_i(in_write_i), .in_lock_i(in_lock_i),
    .cpu_valid_i(cpu_valid_i), .cpu_addr_i(cpu_addr_i), .cpu_grant_o(cpu_grant_o),
    .snp_valid_o(snp_valid_o), .snp_addr_o(snp_addr_o),
    .snp_resp_valid_i(snp_resp_valid_i), .snp_resp_i(snp_resp_i),
    .mem_valid_o(mem_valid_o), .mem_ready_i(mem_ready_i), .mem_addr_o(mem_addr_o),
    .mem_data_o(mem_data_o), .mem_write_o(mem_write_o)
  );

  typedef struct packed {
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    logic          wr;
  } item_t;

  item_t         exp_mem[$];
  logic [AW-1:0] exp_snp[$];
  logic [AW-1:0] drained[$];
  int checks = 0, fails = 0, mem_fires = 0, snoops_seen = 0, push_cnt = 0;
  bit hitm_next = 1'b0;
  int cyc = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic w, input logic l);
    @(negedge clk);
    in_addr_i = a; in_data_i = d; in_write_i = w; in_lock_i = l; in_valid_i = 1'b1;
    #1;
    while (!in_ready_o) begin
      @(negedge clk); #1;
    end
    exp_mem.push_back('{addr: a, data: d, wr: w});
    if (!no_snoop_i) exp_snp.push_back(a);
    @(posedge clk);
    @(negedge clk);
    in_valid_i = 1'b0; in_lock_i = 1'b0;
  endtask

  task automatic drain_all();
    @(negedge clk);
    mem_ready_i = 1'b1;
    while (exp_mem.size() != 0 || exp_snp.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // monitor: snoop responder and memory scoreboard
  always begin
    @(negedge clk);
    #2;
    snp_resp_valid_i = 1'b0;
    if (push_cnt > 0) begin
      push_cnt--;
      if (push_cnt == 0) begin
        snp_resp_valid_i = 1'b1;
        snp_resp_i = 2'd2;
      end
    end else if (snp_valid_o) begin
      snoops_seen++;
      if (exp_snp.size() == 0) chk(1'b0, "R5 unexpected snoop", snp_addr_o, 0);
      else chk(snp_addr_o == exp_snp[0], "R4 snoop order", snp_addr_o, exp_snp[0]);
      if (exp_snp.size() != 0) void'(exp_snp.pop_front());
      snp_resp_valid_i = 1'b1;
      if (hitm_next) begin
        hitm_next = 1'b0;
        snp_resp_i = 2'd1;
        push_cnt = 8;
      end else snp_resp_i = 2'd0;
    end
    if (mem_valid_o && mem_ready_i) begin
      int hit;
      hit = -1;
      mem_fires++;
      drained.push_back(mem_addr_o);
      foreach (exp_mem[k]) if (hit < 0 && exp_mem[k].addr == mem_addr_o) hit = k;
      if (hit < 0) chk(1'b0, "R3 unexpected mem addr", mem_addr_o, 0);
      else begin
        chk(mem_data_o == exp_mem[hit].data && mem_write_o == exp_mem[hit].wr,
            "R3 mem data/dir", {mem_write_o, mem_data_o}, {exp_mem[hit].wr, exp_mem[hit].data});
        exp_mem.delete(hit);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 50000) begin
      checks++; fails++;
      $display("FAIL watchdog act=%0d exp=done", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    #1;
    chk(in_ready_o && !snp_valid_o && !mem_valid_o && !cpu_grant_o, "R1 reset outputs",
        {in_ready_o, snp_valid_o, mem_valid_o, cpu_grant_o}, 4'b1000);
    rst_ni = 1'b1;

    // R4: snoops in acceptance order, memory held off
    no_snoop_i = 1'b0; mem_ready_i = 1'b0;
    send(32'h100, 32'hA1, 1'b1, 1'b0);
    send(32'h200, 32'hA2, 1'b1, 1'b0);
    send(32'h300, 32'hA3, 1'b0, 1'b0);
    repeat (10) @(negedge clk);
    chk(snoops_seen == 3, "R4 snoop count", snoops_seen, 3);
    drain_all();

    // R2 full pool, R10 out-of-order retirement
    no_snoop_i = 1'b1; mem_ready_i = 1'b0;
    for (int i = 0; i < 8; i++) send(32'h8000 + i * 32, 32'hB0 + i, 1'b1, 1'b0);
    @(negedge clk);
    in_addr_i = 32'h9000; in_write_i = 1'b1; in_valid_i = 1'b1;
    #1;
    chk(!in_ready_o, "R2 full stalls", in_ready_o, 0);
    @(negedge clk);
    in_valid_i = 1'b0;
    drained.delete();
    mem_ready_i = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    mem_ready_i = 1'b0;
    #1;
    chk(in_ready_o, "R2 ready after drain", in_ready_o, 1);
    send(32'hA000, 32'hC0, 1'b1, 1'b0);
    send(32'hA020, 32'hC1, 1'b1, 1'b0);
    send(32'hA040, 32'hC2, 1'b1, 1'b0);
    drain_all();
    chk(drained.size() == 11, "R3 drain count", drained.size(), 11);
    if (drained.size() > 3)
      chk(drained[3] == 32'hA000, "R10 newer lower entry retires first", drained[3], 32'hA000);
    mem_ready_i = 1'b0;

    // R6 line hazard
    send(32'h2000, 32'hD0, 1'b1, 1'b0);
    @(negedge clk);
    in_addr_i = 32'h201C; in_write_i = 1'b0; in_valid_i = 1'b1;
    #1;
    chk(!in_ready_o, "R6 read vs pending write same line", in_ready_o, 0);
    @(negedge clk);
    in_valid_i = 1'b0;
    send(32'h2020, 32'hD1, 1'b0, 1'b0);
    @(negedge clk);
    in_addr_i = 32'h2030; in_write_i = 1'b1; in_valid_i = 1'b1;
    #1;
    chk(!in_ready_o, "R6 write vs pending read same line", in_ready_o, 0);
    @(negedge clk);
    in_valid_i = 1'b0;
    drain_all();
    mem_ready_i = 1'b0;
    send(32'h201C, 32'hD2, 1'b0, 1'b0);
    chk(exp_mem.size() == 1, "R6 accepted after drain", exp_mem.size(), 1);
    drain_all();
    mem_ready_i = 1'b0;

    // R7 lock hold-off with snooping on
    no_snoop_i = 1'b0;
    send(32'h4000, 32'hE0, 1'b0, 1'b1);
    repeat (4) @(negedge clk);
    cpu_valid_i = 1'b1; cpu_addr_i = 32'h401C;
    #1;
    chk(!cpu_grant_o, "R7 locked line held", cpu_grant_o, 0);
    cpu_addr_i = 32'h4020;
    #1;
    chk(cpu_grant_o, "R7 other line granted", cpu_grant_o, 1);
    drain_all();
    cpu_addr_i = 32'h401C;
    #1;
    chk(cpu_grant_o, "R7 released after drain", cpu_grant_o, 1);
    mem_ready_i = 1'b0;

    // R8 lock ignored, R5 no snoop
    no_snoop_i = 1'b1;
    base = snoops_seen;
    send(32'h5000, 32'hF0, 1'b0, 1'b1);
    cpu_addr_i = 32'h5004;
    #1;
    chk(cpu_grant_o, "R8 lock ignored when no-snoop", cpu_grant_o, 1);
    repeat (6) @(negedge clk);
    chk(snoops_seen == base, "R5 no snoop issued", snoops_seen, base);
    drain_all();
    cpu_valid_i = 1'b0;

    // R9 modified hit holds memory until push done
    no_snoop_i = 1'b0;
    mem_ready_i = 1'b1;
    hitm_next = 1'b1;
    base = mem_fires;
    send(32'h6000, 32'h66, 1'b1, 1'b0);
    repeat (5) @(negedge clk);
    chk(mem_fires == base, "R9 held during push", mem_fires, base);
    repeat (12) @(negedge clk);
    chk(mem_fires == base + 1, "R9 drained after done", mem_fires, base + 1);

    chk(exp_mem.size() == 0 && exp_snp.size() == 0, "R3 scoreboard empty",
        exp_mem.size() + exp_snp.size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule